// File: doc/BRIEF.md
# Quad DAC Control Register Bank

This block keeps the register state behind a four-channel voltage DAC. A serial front end, outside this block, gathers each 16-bit command word and hands it over together with a per-channel select mask. The block writes the word into the input register of every selected channel. When the front end signals that the write sequence has finished, all channels copy their input registers to their DAC registers at once. The DAC registers drive the channel codes and the per-channel range and reference-buffer flags.

The four most significant bits of each word are control bits. Bit 15 selects the double output range and bit 14 buffers the reference. Bit 13 and bit 12 are active-low clear and power-down commands. Both act on the whole device once the sequence ends. The low twelve bits hold a left-justified code, and the resolution (8, 10 or 12 bits) is a parameter. A combinational readback port returns the stored input word of one selected channel.

Top module: `quad_dac_regbank`

## Requirements
- R1: After reset every channel code, range flag and buffer flag is 0, powerDown is 0, and rdWord is 0 for any mask.
- R2: A wrStrobe loads the word, with its unused low bits zeroed, into the input register of each channel selected in chanMask. The DAC outputs do not change until a seqEnd.
- R3: A seqEnd that follows at least one accepted write copies every input register to its DAC register. The channel's code becomes bits [11:12-DAC_BITS], gainHi becomes bit 15 and refBuf becomes bit 14. The new values appear on the cycle after the strobe.
- R4: Data bits below the DAC resolution are ignored. They do not reach the code, and they read back as 0.
- R5: chanMask bit 0 selects channel A, bit 1 B, bit 2 C and bit 3 D. Every selected channel receives the same word.
- R6: If the last accepted word of a sequence has bit 13 at 0, the seqEnd zeroes all input and DAC registers of all four channels.
- R7: At a seqEnd that closes a sequence, powerDown becomes the inverse of bit 12 of the last accepted word. 0 powers down and 1 restores normal operation.
- R8: Only the last word of a sequence decides clear and power-down. A seqEnd with no accepted write since the previous seqEnd changes nothing.
- R9: A write with an all-zero mask changes no channel register, but its clear and power-down bits still act at the seqEnd.
- R10: rdWord shows the input word of the lowest-lettered selected channel, or 0 when the mask is zero.
- R11: A wrStrobe in the same cycle as seqEnd is ignored. It loads no register and does not count toward any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanMask | input | 4 | Channel select, bit 0 = A … bit 3 = D; also selects readback |
| wrData | input | 16 | Assembled command word |
| wrStrobe | input | 1 | Load wrData into selected input registers |
| seqEnd | input | 1 | End of write sequence |
| dacCode | output | 4*DAC_BITS | Channel codes, channel A in the lowest slice |
| gainHi | output | 4 | Per-channel double range flag |
| refBuf | output | 4 | Per-channel reference buffer flag |
| powerDown | output | 1 | Global power-down |
| rdWord | output | 16 | Readback of the selected input word |

## Verification
The checker's properties hold on every cycle. The DAC-side outputs and powerDown stay unchanged except on the cycle after a seqEnd. A clearing sequence leaves every DAC output at zero, an empty mask reads back zero, and bits below the resolution always read back as zero. Some behaviours need the bench's ordered scenarios. These are the copy of a word to exactly the masked channels, last-word-wins control inside a multi-word sequence, an empty sequence having no effect, a write that coincides with seqEnd being dropped, and the priority of the readback selection.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_COUNT = 4;
  localparam int WORD_W   = 16;
  localparam int GAIN_BIT = 15;
  localparam int BUF_BIT  = 14;
  localparam int CLR_BIT  = 13;
  localparam int PD_BIT   = 12;
  localparam int DATA_MSB = 11;

  typedef struct packed {
    logic [CH_COUNT-1:0] load;
    logic                commit;
    logic                clearAll;
    logic                pdValue;
  } ctlStrobes_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] chanMask,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                wrStrobe,
  input  logic                seqEnd,
  output ctlStrobes_t         strobes
);
  logic pendValid;
  logic pendClr;
  logic pendPd;
  logic acceptWr;

  assign acceptWr = wrStrobe & ~seqEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendClr   <= 1'b1;
      pendPd    <= 1'b1;
    end else if (seqEnd) begin
      pendValid <= 1'b0;
    end else if (acceptWr) begin
      pendValid <= 1'b1;
      pendClr   <= wrData[CLR_BIT];
      pendPd    <= wrData[PD_BIT];
    end
  end

  always_comb begin
    strobes.load     = acceptWr ? chanMask : '0;
    strobes.commit   = seqEnd & pendValid;
    strobes.clearAll = seqEnd & pendValid & ~pendClr;
    strobes.pdValue  = ~pendPd;
  end
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [CH_COUNT-1:0]          chanMask,
  output logic [CH_COUNT*DAC_BITS-1:0] dacCode,
  output logic [CH_COUNT-1:0]          gainHi,
  output logic [CH_COUNT-1:0]          refBuf,
  output logic                         powerDown,
  output logic [WORD_W-1:0]            rdWord
);
  localparam int PAD = DATA_MSB + 1 - DAC_BITS;
  localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << PAD) - WORD_W'(1));

  logic [WORD_W-1:0] inWord [CH_COUNT];

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inWord[ch]                       <= '0;
        dacCode[ch*DAC_BITS +: DAC_BITS] <= '0;
        gainHi[ch]                       <= 1'b0;
        refBuf[ch]                       <= 1'b0;
      end else if (strobes.clearAll) begin
        inWord[ch]                       <= '0;
        dacCode[ch*DAC_BITS +: DAC_BITS] <= '0;
        gainHi[ch]                       <= 1'b0;
        refBuf[ch]                       <= 1'b0;
      end else begin
        if (strobes.load[ch]) inWord[ch] <= wrData & KEEP;
        if (strobes.commit) begin
          dacCode[ch*DAC_BITS +: DAC_BITS] <= inWord[ch][DATA_MSB -: DAC_BITS];
          gainHi[ch]                       <= inWord[ch][GAIN_BIT];
          refBuf[ch]                       <= inWord[ch][BUF_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               powerDown <= 1'b0;
    else if (strobes.commit) powerDown <= strobes.pdValue;
  end

  always_comb begin
    rdWord = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (chanMask[i]) rdWord = inWord[i];
    end
  end
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [3:0]                   chanMask,
  input  logic [15:0]                  wrData,
  input  logic                         wrStrobe,
  input  logic                         seqEnd,
  output logic [4*DAC_BITS-1:0]        dacCode,
  output logic [3:0]                   gainHi,
  output logic [3:0]                   refBuf,
  output logic                         powerDown,
  output logic [15:0]                  rdWord
);
  ctlStrobes_t strobes;

  qdac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chanMask (chanMask),
    .wrData   (wrData),
    .wrStrobe (wrStrobe),
    .seqEnd   (seqEnd),
    .strobes  (strobes)
  );

  qdac_datapath #(.DAC_BITS(DAC_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .chanMask  (chanMask),
    .dacCode   (dacCode),
    .gainHi    (gainHi),
    .refBuf    (refBuf),
    .powerDown (powerDown),
    .rdWord    (rdWord)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int DAC_BITS = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [3:0]            chanMask,
  input logic [15:0]           wrData,
  input logic                  wrStrobe,
  input logic                  seqEnd,
  input logic [4*DAC_BITS-1:0] dacCode,
  input logic [3:0]            gainHi,
  input logic [3:0]            refBuf,
  input logic                  powerDown,
  input logic [15:0]           rdWord
);
  logic seenWr;
  logic seenClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenWr  <= 1'b0;
      seenClr <= 1'b1;
    end else if (seqEnd) begin
      seenWr <= 1'b0;
    end else if (wrStrobe) begin
      seenWr  <= 1'b1;
      seenClr <= wrData[13];
    end
  end

  assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !seqEnd |=> ($stable(dacCode) && $stable(gainHi) && $stable(refBuf)));

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !seqEnd |=> $stable(powerDown));

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (seqEnd && seenWr && !seenClr) |=> (dacCode == '0 && gainHi == '0 && refBuf == '0));

  assert_empty_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seqEnd && !seenWr) |=> ($stable(dacCode) && $stable(powerDown)));

  always_comb begin
    if (rstN) begin
      assert_rd_empty_R10: assert (chanMask != 4'b0000 || rdWord == 16'h0000);
    end
  end

  if (DAC_BITS < 12) begin : g_lowbits
    always_comb begin
      if (rstN) begin
        assert_low_bits_R4: assert (rdWord[11-DAC_BITS:0] == '0);
      end
    end
  end
endmodule

bind quad_dac_regbank qdac_checker #(.DAC_BITS(DAC_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanMask  (chanMask),
  .wrData    (wrData),
  .wrStrobe  (wrStrobe),
  .seqEnd    (seqEnd),
  .dacCode   (dacCode),
  .gainHi    (gainHi),
  .refBuf    (refBuf),
  .powerDown (powerDown),
  .rdWord    (rdWord)
);

// File: tb/quad_dac_regbank_bench.sv
`timescale 1ns/100ps
module quad_dac_regbank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chanMask = 4'b0000;
  logic [15:0] wrData = 16'h0000;
  logic        wrStrobe = 1'b0;
  logic        seqEnd = 1'b0;
  logic [47:0] dacCode;
  logic [3:0]  gainHi, refBuf;
  logic        powerDown;
  logic [15:0] rdWord;
  logic [31:0] dacCode8;
  logic [3:0]  gainHi8, refBuf8;
  logic        powerDown8;
  logic [15:0] rdWord8;

  int checkCount = 0;
  int failCount  = 0;

  always #2 clk = ~clk;

  quad_dac_regbank #(.DAC_BITS(12)) u_quad_dac_regbank (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .wrData(wrData),
    .wrStrobe(wrStrobe), .seqEnd(seqEnd), .dacCode(dacCode), .gainHi(gainHi),
    .refBuf(refBuf), .powerDown(powerDown), .rdWord(rdWord)
  );

  quad_dac_regbank #(.DAC_BITS(8)) u_quad_dac_regbank_b8 (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .wrData(wrData),
    .wrStrobe(wrStrobe), .seqEnd(seqEnd), .dacCode(dacCode8), .gainHi(gainHi8),
    .refBuf(refBuf8), .powerDown(powerDown8), .rdWord(rdWord8)
  );

  typedef struct {
    logic [47:0] code;
    logic [3:0]  gain;
    logic [3:0]  bufF;
    logic        pd;
    logic [15:0] rd;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  logic [15:0] mIn [4];
  logic [47:0] mCode;
  logic [3:0]  mGain, mBuf;
  logic        mPd, mPend, mPendClr, mPendPd;

  function automatic logic [15:0] modelRd(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return mIn[i];
    return 16'h0000;
  endfunction

  task automatic pushExp(input string tag);
    expItem_t it;
    it.code = mCode; it.gain = mGain; it.bufF = mBuf; it.pd = mPd;
    it.rd = modelRd(chanMask); it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step(input logic [3:0] m, input logic [15:0] w,
                      input logic wr, input logic se, input string tag);
    @(negedge clk);
    chanMask = m; wrData = w; wrStrobe = wr; seqEnd = se;
    @(posedge clk);
    #1;
    if (se) begin
      if (mPend) begin
        if (!mPendClr) begin
          for (int i = 0; i < 4; i++) mIn[i] = 16'h0000;
          mCode = '0; mGain = '0; mBuf = '0;
        end else begin
          for (int i = 0; i < 4; i++) begin
            mCode[i*12 +: 12] = mIn[i][11:0];
            mGain[i] = mIn[i][15];
            mBuf[i]  = mIn[i][14];
          end
        end
        mPd = ~mPendPd;
      end
      mPend = 1'b0;
    end else if (wr) begin
      for (int i = 0; i < 4; i++) if (m[i]) mIn[i] = w;
      mPend = 1'b1; mPendClr = w[13]; mPendPd = w[12];
    end
    pushExp(tag);
    @(negedge clk);
    wrStrobe = 1'b0; seqEnd = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected items and compare after each edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1.5;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(dacCode == it.code, {it.tag, " code"}, 64'(dacCode), 64'(it.code));
        check(gainHi == it.gain && refBuf == it.bufF && powerDown == it.pd,
              {it.tag, " flags"}, 64'({gainHi, refBuf, powerDown}),
              64'({it.gain, it.bufF, it.pd}));
        check(rdWord == it.rd, {it.tag, " readback"}, 64'(rdWord), 64'(it.rd));
      end
    end
  end

  initial begin
    #800000;
    failCount++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mIn[i] = 16'h0000;
    mCode = '0; mGain = '0; mBuf = '0; mPd = 1'b0;
    mPend = 1'b0; mPendClr = 1'b1; mPendPd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, readback for full mask
    step(4'b1111, 16'h0000, 1'b0, 1'b0, "R1 reset");
    // R2: write channel A only, DAC outputs held
    step(4'b0001, 16'hF5A3, 1'b1, 1'b0, "R2 load A");
    // R3: commit copies code and flags
    step(4'b0001, 16'h0000, 1'b0, 1'b1, "R3 commit A");
    #1.2;
    check(dacCode8[7:0] == 8'h5A, "R4 8-bit code", 64'(dacCode8[7:0]), 64'h5A);
    check(rdWord8 == 16'hF5A0, "R4 8-bit readback", 64'(rdWord8), 64'hF5A0);
    // R5 / R10: multi-hot write to D and B, readback shows B
    step(4'b1010, 16'h3123, 1'b1, 1'b0, "R5 R10 load D,B");
    step(4'b1010, 16'h0000, 1'b0, 1'b1, "R5 commit D,B");
    // R8: empty sequence end
    step(4'b0001, 16'h0000, 1'b0, 1'b1, "R8 empty end");
    // R9 / R7: zero-mask write with PD=0
    step(4'b0000, 16'h2FFF, 1'b1, 1'b0, "R9 zero mask");
    step(4'b0001, 16'h0000, 1'b0, 1'b1, "R7 R9 power down");
    // R7: normal write restores power
    step(4'b0100, 16'h7456, 1'b1, 1'b0, "R7 load C");
    step(4'b0100, 16'h0000, 1'b0, 1'b1, "R7 power up");
    // R8: last word wins, first word had CLR=0
    step(4'b0001, 16'h1111, 1'b1, 1'b0, "R8 first word");
    step(4'b0010, 16'h3222, 1'b1, 1'b0, "R8 last word");
    step(4'b0011, 16'h0000, 1'b0, 1'b1, "R8 commit");
    // R11: write coincident with seqEnd ignored
    step(4'b1000, 16'h3999, 1'b1, 1'b1, "R11 coincident");
    step(4'b1000, 16'h0000, 1'b0, 1'b1, "R11 follow end");
    // R10: readback priority walk
    step(4'b1000, 16'h0000, 1'b0, 1'b0, "R10 rd D");
    step(4'b1100, 16'h0000, 1'b0, 1'b0, "R10 rd C");
    step(4'b1111, 16'h0000, 1'b0, 1'b0, "R10 rd A");
    step(4'b0000, 16'h0000, 1'b0, 1'b0, "R10 rd none");
    // R6: clear everything
    step(4'b1111, 16'h1ABC, 1'b1, 1'b0, "R6 load all");
    step(4'b1111, 16'h0000, 1'b0, 1'b1, "R6 clear");
    repeat (4) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule